// File: doc/BRIEF.md
# Multi-Channel Microsecond Timer Unit

The block is a memory-mapped timer unit with five 32-bit channels, A to E, all governed by one shared control word. Channels A to D are event timers. Software stores a count, enables the channel, and the channel raises a one-clock interrupt when the count runs out. A per-channel flag selects whether it then stops by itself or re-arms from the stored count. Channel E is a free-running up counter that software reads as a timestamp.

Every channel advances on a tick that its own select field picks from a shared chain. A prescaler divides the reference clock down to a microsecond tick. Decade stages then divide further, and the raw clock is also offered. Software reaches the unit through a plain 32-bit word bus whose read data is combinational. Each event channel drives its own interrupt line.

Top module: `usec_timer_unit`

## Requirements
- R1: After reset the control word, all four event count registers and the timestamp read zero, and no interrupt is asserted.
- R2: Layout of the control word, which lives at byte offset 0. Channel t's tick select starts at bit 2*t: 2 bits wide for A to D, 3 bits wide at bits 10:8 for E. Periodic flags of A to D sit at bits 12 to 15. Enable bits of A to E sit at bits 16 to 20. All other bits read zero. Event channel t's count register is at byte offset 4*(t+1) and the timestamp is at offset 20. Other word offsets read zero. Accesses whose address bits 1:0 are not zero are ignored and read zero.
- R3: Tick select codes for event channels: 0 is the microsecond tick (one per REF_PER_US clocks), 1 is that tick divided by TICK_STEP, 2 is it divided by TICK_STEP squared, and 3 is the raw clock. Codes for the timestamp: 0 is raw, 1 is microsecond, 2 and 3 are the first and second decade, and 4 to 7 are the third decade.
- R4: A disabled event channel never raises its interrupt.
- R5: In one-shot mode (periodic flag clear) with stored count N, the channel raises its interrupt for exactly one clock, N+1 ticks after being enabled. It then clears its own enable bit and does not fire again.
- R6: In periodic mode with stored count N, the interrupt repeats every N+1 ticks and the enable bit stays set.
- R7: Writing a count register while its channel runs does not alter the countdown in progress. The new value is used at the next enable.
- R8: An event count register reads back the value last written to it.
- R9: While enabled, the timestamp advances by one per selected tick. While disabled it holds. A read returns the live value.
- R10: Writing the timestamp register loads the counter, and the counter wraps from all ones to zero.
- R11: Writing the control word with a channel's enable bit already set does not restart that channel. Clearing the bit and then setting it again restarts the countdown from the stored count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| evt_irq | output | 4 | One-clock interrupt pulse per event channel A to D |

## Verification
On every cycle the assertions check several properties. Reserved control bits stay zero. An interrupt only follows a cycle in which its channel was enabled. A one-shot expiry always drops its own enable, while a periodic expiry keeps it. Stored counts change only on a bus write. The timestamp moves by at most one per cycle when enabled and not written, and stays still when disabled. Exact timing cannot be shown by a per-cycle property and is left to the bench's scenarios: the N+1 tick latency, the repeat interval, each tick select ratio, the deferred effect of a rewrite during a countdown, restart on re-enable, and the wrap of the timestamp.

// File: rtl/utimer_pkg.sv
package utimer_pkg;
   localparam int N_EVT       = 4;
   localparam int N_DEC       = 3;
   localparam int N_TICK      = N_DEC + 2;
   localparam int TK_RAW      = 0;
   localparam int TK_US       = 1;
   localparam int SEL_EVT_W   = 2;
   localparam int SEL_STAMP_W = 3;
   localparam int STAMP_SEL_LSB = 2 * N_EVT;
   localparam int PER_BASE    = 12;
   localparam int EN_BASE     = 16;
   localparam int STAMP_EN    = EN_BASE + N_EVT;
   localparam int CTRL_WORD   = 0;
   localparam int STAMP_WORD  = N_EVT + 1;

   function automatic logic [31:0] ctrl_mask();
      logic [31:0] m;
      m = '0;
      for (int t = 0; t < N_EVT; t++) begin
         m[2*t]          = 1'b1;
         m[2*t+1]        = 1'b1;
         m[PER_BASE + t] = 1'b1;
         m[EN_BASE + t]  = 1'b1;
      end
      for (int b = 0; b < SEL_STAMP_W; b++) m[STAMP_SEL_LSB + b] = 1'b1;
      m[STAMP_EN] = 1'b1;
      return m;
   endfunction

   localparam logic [31:0] CTRL_MASK = ctrl_mask();
endpackage

// File: rtl/utimer_tick_chain.sv
module utimer_tick_chain #(
   parameter int REF_PER_US = 24,
   parameter int TICK_STEP  = 10,
   parameter int N_STAGE    = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   output logic [N_STAGE+1:0] ticks
);
   localparam int PRE_W  = (REF_PER_US > 1) ? $clog2(REF_PER_US) : 1;
   localparam int STEP_W = (TICK_STEP > 1) ? $clog2(TICK_STEP) : 1;

   if (REF_PER_US < 1) begin : g_bad_ref
      $error("REF_PER_US must be at least 1");
   end
   if (TICK_STEP < 2) begin : g_bad_step
      $error("TICK_STEP must be at least 2");
   end

   assign ticks[0] = 1'b1;

   if (REF_PER_US == 1) begin : g_pre_pass
      assign ticks[1] = 1'b1;
   end else begin : g_pre_div
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              pre_q <= '0;
         else if (pre_q == PRE_W'(REF_PER_US-1))  pre_q <= '0;
         else                                     pre_q <= pre_q + 1'b1;
      end
      assign ticks[1] = (pre_q == PRE_W'(REF_PER_US-1));
   end

   for (genvar k = 0; k < N_STAGE; k++) begin : g_dec
      logic [STEP_W-1:0] dec_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dec_q <= '0;
         else if (ticks[k+1]) begin
            if (dec_q == STEP_W'(TICK_STEP-1)) dec_q <= '0;
            else                               dec_q <= dec_q + 1'b1;
         end
      end
      assign ticks[k+2] = ticks[k+1] && (dec_q == STEP_W'(TICK_STEP-1));
   end
endmodule

// File: rtl/utimer_evt_channel.sv
module utimer_evt_channel #(
   parameter int CNT_W = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             enable,
   input  logic             periodic,
   input  logic             arm,
   input  logic [CNT_W-1:0] reload,
   output logic             irq,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;
   logic             expire;

   assign expire = enable && tick && (cnt_q == '0);
   assign done   = expire && !periodic;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= expire && !arm;
         if (arm)                 cnt_q <= reload;
         else if (enable && tick) begin
            if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
            else if (periodic)    cnt_q <= reload;
         end
      end
   end
endmodule

// File: rtl/utimer_stamp_counter.sv
module utimer_stamp_counter #(
   parameter int CNT_W = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             enable,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                value <= '0;
      else if (load)             value <= load_val;
      else if (enable && tick)   value <= value + 1'b1;
   end
endmodule

// File: rtl/usec_timer_unit.sv
module usec_timer_unit
   import utimer_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int REF_PER_US = 24,
   parameter int TICK_STEP  = 10,
   parameter int ADDR_W     = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [N_EVT-1:0]  evt_irq
);
   localparam int WORD_W = ADDR_W - 2;

   if (CNT_W < 16 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie between 16 and 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end

   logic [WORD_W-1:0]               word;
   logic                            aligned;
   logic                            wr_hit;
   logic                            wr_ctrl;
   logic                            wr_stamp;
   logic [N_EVT-1:0]                wr_evt;
   logic [31:0]                     ctrl_q;
   logic [31:0]                     ctrl_nx;
   logic [N_EVT-1:0][CNT_W-1:0]     reload_q;
   logic [N_EVT-1:0]                arm;
   logic [N_EVT-1:0]                evt_done;
   logic [N_TICK-1:0]               ticks;
   logic [CNT_W-1:0]                stamp_val;
   logic                            stamp_tick;

   assign word     = bus_addr[ADDR_W-1:2];
   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign wr_hit   = bus_en && bus_wr && aligned;
   assign wr_ctrl  = wr_hit && (word == WORD_W'(CTRL_WORD));
   assign wr_stamp = wr_hit && (word == WORD_W'(STAMP_WORD));

   utimer_tick_chain #(
      .REF_PER_US (REF_PER_US),
      .TICK_STEP  (TICK_STEP),
      .N_STAGE    (N_DEC)
   ) u_ticks (
      .clk   (clk),
      .rst_n (rst_n),
      .ticks (ticks)
   );

   always_comb begin
      ctrl_nx = ctrl_q;
      for (int t = 0; t < N_EVT; t++)
         if (evt_done[t]) ctrl_nx[EN_BASE + t] = 1'b0;
      if (wr_ctrl) ctrl_nx = bus_wdata & CTRL_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reload_q <= '0;
      else begin
         for (int t = 0; t < N_EVT; t++)
            if (wr_evt[t]) reload_q[t] <= bus_wdata[CNT_W-1:0];
      end
   end

   for (genvar t = 0; t < N_EVT; t++) begin : g_evt
      logic [SEL_EVT_W-1:0] sel;
      logic                 tick_sel;

      assign wr_evt[t] = wr_hit && (word == WORD_W'(t + 1));
      assign sel       = ctrl_q[2*t +: SEL_EVT_W];
      assign arm[t]    = ctrl_nx[EN_BASE + t] && !ctrl_q[EN_BASE + t];

      always_comb begin
         case (sel)
            2'd0:    tick_sel = ticks[TK_US];
            2'd1:    tick_sel = ticks[TK_US + 1];
            2'd2:    tick_sel = ticks[TK_US + 2];
            default: tick_sel = ticks[TK_RAW];
         endcase
      end

      utimer_evt_channel #(.CNT_W(CNT_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick_sel),
         .enable   (ctrl_q[EN_BASE + t]),
         .periodic (ctrl_q[PER_BASE + t]),
         .arm      (arm[t]),
         .reload   (reload_q[t]),
         .irq      (evt_irq[t]),
         .done     (evt_done[t])
      );
   end

   always_comb begin
      case (ctrl_q[STAMP_SEL_LSB +: SEL_STAMP_W])
         3'd0:    stamp_tick = ticks[TK_RAW];
         3'd1:    stamp_tick = ticks[TK_US];
         3'd2:    stamp_tick = ticks[TK_US + 1];
         3'd3:    stamp_tick = ticks[TK_US + 2];
         default: stamp_tick = ticks[TK_US + 3];
      endcase
   end

   utimer_stamp_counter #(.CNT_W(CNT_W)) u_stamp (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (stamp_tick),
      .enable   (ctrl_q[STAMP_EN]),
      .load     (wr_stamp),
      .load_val (bus_wdata[CNT_W-1:0]),
      .value    (stamp_val)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_wr && aligned) begin
         if (word == WORD_W'(CTRL_WORD))       bus_rdata = ctrl_q;
         else if (word == WORD_W'(STAMP_WORD)) bus_rdata = 32'(stamp_val);
         else begin
            for (int t = 0; t < N_EVT; t++)
               if (word == WORD_W'(t + 1)) bus_rdata = 32'(reload_q[t]);
         end
      end
   end
endmodule

// File: rtl/utimer_checker.sv
module utimer_checker
   import utimer_pkg::*;
#(
   parameter int CNT_W = 32
)(
   input logic                        clk,
   input logic                        rst_n,
   input logic [31:0]                 ctrl_q,
   input logic [N_EVT-1:0]            evt_irq,
   input logic                        wr_ctrl,
   input logic [N_EVT-1:0]            wr_evt,
   input logic                        wr_stamp,
   input logic [CNT_W-1:0]            stamp_val,
   input logic [N_EVT-1:0][CNT_W-1:0] reload_q
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTRL_MASK) == 32'd0);  // R2

   for (genvar t = 0; t < N_EVT; t++) begin : g_chk
      AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         evt_irq[t] |-> $past(ctrl_q[EN_BASE + t]));  // R4

      AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_irq[t] && !$past(ctrl_q[PER_BASE + t]) && !$past(wr_ctrl))
            |-> !ctrl_q[EN_BASE + t]);  // R5

      AST_PERIODIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_irq[t] && $past(ctrl_q[PER_BASE + t]) && !$past(wr_ctrl))
            |-> ctrl_q[EN_BASE + t]);  // R6

      AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(wr_evt[t]) |-> $stable(reload_q[t]));  // R8
   end

   AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctrl_q[STAMP_EN]) && !$past(wr_stamp))
         |-> (CNT_W'(stamp_val - $past(stamp_val)) <= CNT_W'(1)));  // R9

   AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ctrl_q[STAMP_EN]) && !$past(wr_stamp)) |-> $stable(stamp_val));  // R9
endmodule

bind usec_timer_unit utimer_checker #(.CNT_W(CNT_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_q    (ctrl_q),
   .evt_irq   (evt_irq),
   .wr_ctrl   (wr_ctrl),
   .wr_evt    (wr_evt),
   .wr_stamp  (wr_stamp),
   .stamp_val (stamp_val),
   .reload_q  (reload_q)
);

// File: tb/usec_timer_unit_test.sv
`timescale 1ns/1ps
module usec_timer_unit_test;
   localparam int REF = 3;
   localparam int STP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  evt_irq;

   usec_timer_unit #(
      .CNT_W(32), .REF_PER_US(REF), .TICK_STEP(STP), .ADDR_W(5)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_irq(evt_irq)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 1'b0;
   int irq_cnt[4];
   int irq_first[4];
   int irq_last[4];
   int gap_min[4];
   int gap_max[4];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      for (int t = 0; t < 4; t++) begin
         if (evt_irq[t]) begin
            if (irq_cnt[t] == 0) irq_first[t] = cyc;
            else begin
               if (cyc - irq_last[t] < gap_min[t]) gap_min[t] = cyc - irq_last[t];
               if (cyc - irq_last[t] > gap_max[t]) gap_max[t] = cyc - irq_last[t];
            end
            irq_last[t] = cyc;
            irq_cnt[t]++;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      for (int t = 0; t < 4; t++) begin
         irq_cnt[t] = 0; irq_first[t] = 0; irq_last[t] = 0;
         gap_min[t] = 1000000; gap_max[t] = 0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_en = 1'b0;
      #1;
   endtask

   function automatic logic [31:0] evt_cfg(int t, int sel, bit per, bit en);
      return (32'(sel) << (2*t)) | (32'(per) << (12+t)) | (32'(en) << (16+t));
   endfunction

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8ns * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v, v2;
      int w;
      clear_stats();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state on every mapped word and the interrupt lines
      for (int a = 0; a < 6; a++) begin
         rd(5'(a*4), v);
         chk($sformatf("R1 word %0d", a), v, 32'd0);
      end
      chk("R1 irq", {28'd0, evt_irq}, 32'd0);

      // R2 control layout and reserved bits
      wr(5'h00, 32'hFFFF_FFFF);
      rd(5'h00, v);
      chk("R2 ctrl mask", v, 32'h001F_F7FF);
      wr(5'h00, 32'd0);
      rd(5'h18, v); chk("R2 unmapped 0x18", v, 32'd0);
      rd(5'h1C, v); chk("R2 unmapped 0x1C", v, 32'd0);
      wr(5'h01, 32'h0001_0000);
      rd(5'h00, v); chk("R2 misaligned write ignored", v, 32'd0);
      wr(5'h04, 32'h0000_1234);
      rd(5'h05, v); chk("R2 misaligned read zero", v, 32'd0);
      idle(3);

      // R8 count registers read back per channel
      for (int t = 0; t < 4; t++) begin
         wr(5'((t+1)*4), 32'hA5A5_0000 + 32'(t));
         rd(5'((t+1)*4), v);
         chk($sformatf("R8 count ch%0d", t), v, 32'hA5A5_0000 + 32'(t));
      end

      // R4 disabled channels stay silent
      for (int t = 0; t < 4; t++) wr(5'((t+1)*4), 32'd0);
      clear_stats();
      wr(5'h00, 32'h0000_F0FF);
      idle(20);
      chk("R4 no irq while disabled", 32'(irq_cnt[0]+irq_cnt[1]+irq_cnt[2]+irq_cnt[3]), 32'd0);
      wr(5'h00, 32'd0);

      // R5 one-shot sweep, raw clock, all event channels
      for (int t = 0; t < 4; t++) begin
         for (int n = 0; n < 7; n++) begin
            wr(5'((t+1)*4), 32'(n));
            idle(2);
            clear_stats();
            wr(5'h00, evt_cfg(t, 3, 1'b0, 1'b1));
            w = cyc;
            idle(n + 12);
            chk($sformatf("R5 latency ch%0d n%0d", t, n), 32'(irq_first[t] - w), 32'(n + 1));
            chk($sformatf("R5 single pulse ch%0d n%0d", t, n), 32'(irq_cnt[t]), 32'd1);
            chk($sformatf("R4 others quiet ch%0d n%0d", t, n),
                32'(irq_cnt[0]+irq_cnt[1]+irq_cnt[2]+irq_cnt[3]-irq_cnt[t]), 32'd0);
            rd(5'h00, v);
            chk($sformatf("R5 enable cleared ch%0d n%0d", t, n), v, evt_cfg(t, 3, 1'b0, 1'b0));
            wr(5'h00, 32'd0);
         end
      end

      // R6 periodic repeat interval, raw clock
      for (int t = 0; t < 4; t++) begin
         for (int n = 2; n < 6; n += 3) begin
            wr(5'((t+1)*4), 32'(n));
            idle(2);
            clear_stats();
            wr(5'h00, evt_cfg(t, 3, 1'b1, 1'b1));
            w = cyc;
            idle(5 * (n + 1) + 2);
            rd(5'h00, v);
            chk($sformatf("R6 enable kept ch%0d", t), v, evt_cfg(t, 3, 1'b1, 1'b1));
            wr(5'h00, 32'd0);
            idle(2);
            chk($sformatf("R6 first ch%0d n%0d", t, n), 32'(irq_first[t] - w), 32'(n + 1));
            chk($sformatf("R6 gap min ch%0d n%0d", t, n), 32'(gap_min[t]), 32'(n + 1));
            chk($sformatf("R6 gap max ch%0d n%0d", t, n), 32'(gap_max[t]), 32'(n + 1));
         end
      end

      // R3 event tick selects on channel A (periodic gaps)
      for (int s = 0; s < 3; s++) begin
         int per;
         per = (s == 0) ? REF : (s == 1) ? REF*STP : REF*STP*STP;
         wr(5'h04, 32'd1);
         idle(2);
         clear_stats();
         wr(5'h00, evt_cfg(0, s, 1'b1, 1'b1));
         idle(2 * per * 4 + 4);
         wr(5'h00, 32'd0);
         idle(2);
         chk($sformatf("R3 evt sel %0d gap min", s), 32'(gap_min[0]), 32'(2 * per));
         chk($sformatf("R3 evt sel %0d gap max", s), 32'(gap_max[0]), 32'(2 * per));
      end

      // R3 and R9 timestamp tick selects
      for (int s = 0; s < 8; s++) begin
         int per;
         per = (s == 0) ? 1 : (s == 1) ? REF : (s == 2) ? REF*STP :
               (s == 3) ? REF*STP*STP : REF*STP*STP*STP;
         wr(5'h00, (32'(s) << 8) | 32'h0010_0000);
         idle(1);
         rd(5'h14, v);
         idle(per * 3);
         rd(5'h14, v2);
         chk($sformatf("R3 R9 stamp sel %0d", s), v2 - v, 32'd3);
      end

      // R9 timestamp holds while disabled
      wr(5'h00, 32'd0);
      rd(5'h14, v);
      idle(25);
      rd(5'h14, v2);
      chk("R9 stamp holds", v2, v);

      // R10 load and wrap
      wr(5'h14, 32'hFFFF_FFFE);
      rd(5'h14, v);
      chk("R10 stamp load", v, 32'hFFFF_FFFE);
      wr(5'h00, 32'h0010_0000);
      idle(3);
      rd(5'h14, v);
      chk("R10 stamp wrap", v, 32'h0000_0001);
      wr(5'h00, 32'd0);

      // R7 rewrite during countdown is deferred
      wr(5'h08, 32'd10);
      idle(2);
      clear_stats();
      wr(5'h00, evt_cfg(1, 3, 1'b0, 1'b1));
      w = cyc;
      wr(5'h08, 32'd2);
      idle(15);
      chk("R7 running countdown kept", 32'(irq_first[1] - w), 32'd11);
      chk("R7 single pulse", 32'(irq_cnt[1]), 32'd1);
      rd(5'h08, v);
      chk("R8 rewritten value", v, 32'd2);
      clear_stats();
      wr(5'h00, evt_cfg(1, 3, 1'b0, 1'b1));
      w = cyc;
      idle(8);
      chk("R7 new value at next enable", 32'(irq_first[1] - w), 32'd3);
      wr(5'h00, 32'd0);

      // R11 rewrite with enable set does not restart; re-enable does
      wr(5'h0C, 32'd6);
      idle(2);
      clear_stats();
      wr(5'h00, evt_cfg(2, 3, 1'b0, 1'b1));
      w = cyc;
      wr(5'h00, evt_cfg(2, 3, 1'b0, 1'b1));
      idle(12);
      chk("R11 no restart", 32'(irq_first[2] - w), 32'd7);
      wr(5'h00, evt_cfg(2, 3, 1'b1, 1'b1));
      w = cyc;
      idle(3);
      wr(5'h00, 32'd0);
      clear_stats();
      wr(5'h00, evt_cfg(2, 3, 1'b1, 1'b1));
      w = cyc;
      idle(10);
      chk("R11 restart after re-enable", 32'(irq_first[2] - w), 32'd7);
      wr(5'h00, 32'd0);
      idle(2);

      finished = 1'b1;
      finish_run();
   end
endmodule